// File: doc/BRIEF.md
# Pointer-Based Register Bank in Shared RAM

This block provides a working register set that lives in an ordinary word-wide RAM instead of in dedicated flops. A base pointer register selects where in the RAM the active bank of sixteen 16-bit registers starts. Register operands arrive as short codes. The block turns each code into a RAM word index plus a byte lane or bit position. It then performs a read, a lane-masked write, or a read-modify-write of a single bit.

Moving the pointer selects another bank, and the contents of every bank stay in the RAM. A swap operation loads a new pointer and, in the same operation, captures the pointer it replaces so that the caller can store it away. The byte and bit views overlay the same words as the word view, so all three views of one location always agree.

Top module: `ctxbank_unit`

## Requirements
- R1: After reset the pointer reads zero and `rd_valid`, `busy` and `swap_done` are low.
- R2: Word register n (kind 2'b00, n = `acc_code[3:0]`) is the RAM word at byte address pointer + 2·n. The bank runs upward from the pointer, and each register keeps its own value.
- R3: For a byte code b (kind 2'b01, b = `acc_code[3:0]`), the register is word b>>1 and b[0]=1 selects the high byte (the odd address). A byte write changes only that lane. A byte read returns the byte zero-extended to 16 bits. Only words 0 to 7 can be reached this way.
- R4: A short code (kind 2'b11) selects word register `acc_code[1:0]` (0 to 3) and ignores `acc_code[7:2]`.
- R5: A bit code (kind 2'b10) takes the register from `acc_code[7:4]` and the bit from `acc_code[3:0]`. A bit read returns that bit in `rd_data[0]` with every other bit zero.
- R6: A bit write reads the word and writes it back one cycle later with only the addressed bit set to `acc_wdata[0]`. `busy` is high for exactly the one cycle after the request.
- R7: `cp_load` loads the pointer with bit 0 forced to zero. An access in the next cycle uses the new pointer. An access in the same cycle as the load uses the old one.
- R8: `cp_swap` loads the pointer from `cp_swap_val` (bit 0 forced to zero). In the next cycle `swap_done` is high and `swap_old` holds the pointer that was active before the swap. If `cp_swap` and `cp_load` are high together, the swap wins.
- R9: Register addresses wrap modulo the RAM byte size 2^ADDR_W.
- R10: Each read request gives `rd_valid` high for exactly one cycle, in the cycle after the request. Writes never raise `rd_valid`.
- R11: Banks at different pointers keep their contents independently across pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cp_load | input | 1 | Load the pointer from `cp_load_val` |
| cp_load_val | input | ADDR_W | New pointer value for a plain load |
| cp_swap | input | 1 | Swap: load a new pointer and capture the old one |
| cp_swap_val | input | ADDR_W | New pointer value for a swap |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_kind | input | 2 | 00 word, 01 byte, 10 bit, 11 short word code |
| acc_code | input | 8 | Operand code |
| acc_wdata | input | 16 | Write data (byte: bits 7:0, bit: bit 0) |
| busy | output | 1 | Bit write-back in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read result |
| cp_value | output | ADDR_W | Current pointer |
| swap_old | output | ADDR_W | Pointer replaced by the last swap |
| swap_done | output | 1 | One-cycle pulse after a swap |

## Verification
The assertions take for granted that no access is requested while `busy` is high. This is the one cycle in which the RAM port carries the write-back of a bit write. The stimulus respects this by always following a bit write with an idle cycle, in both the directed and the random phases. The stimulus also keeps `acc_valid` low until the internal reset release has completed. The pointer inputs may change in any cycle, including together with an access and together with each other.

// File: rtl/ctxbank_pkg.sv
package ctxbank_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned LANES   = 2;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned NREG_W  = 4;
  localparam int unsigned OFS_W   = NREG_W + 1;

  typedef enum logic [1:0] {
    KIND_WORD4 = 2'b00,
    KIND_BYTE4 = 2'b01,
    KIND_BIT8  = 2'b10,
    KIND_WORD2 = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/ctxbank_rstsync.sv
module ctxbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ctxbank_ptr.sv
module ctxbank_ptr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              swap_en,
  input  logic [ADDR_W-1:0] swap_val,
  output logic [ADDR_W-1:0] cp_q,
  output logic [ADDR_W-1:0] old_q,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(1);

  logic [ADDR_W-1:0] cp_d, old_d;
  logic              cp_en, old_en;

  // next state: swap has priority over plain load
  always_comb begin
    cp_en  = load_en | swap_en;
    old_en = swap_en;
    old_d  = cp_q;
    if (swap_en) cp_d = swap_val & ALIGN;
    else         cp_d = load_val & ALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q   <= '0;
      old_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= swap_en;
      if (cp_en)  cp_q  <= cp_d;
      if (old_en) old_q <= old_d;
    end
  end

  assert_swap_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (old_q == $past(cp_q)));

  assert_swap_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && load_en) |=> (cp_q == ($past(swap_val) & ALIGN)));

  assert_cp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !swap_en) |=> $stable(cp_q));
endmodule

// File: rtl/ctxbank_addr.sv
module ctxbank_addr
  import ctxbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] cp,
  input  acc_kind_e         kind,
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              lane_hi,
  output logic [3:0]        bit_sel
);
  logic [NREG_W-1:0] reg_n;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    unique case (kind)
      KIND_WORD4: reg_n = code[3:0];
      KIND_BYTE4: reg_n = {1'b0, code[3:1]};
      KIND_BIT8:  reg_n = code[7:4];
      default:    reg_n = {2'b00, code[1:0]};
    endcase
    ofs       = {reg_n, 1'b0};
    byte_addr = cp + ADDR_W'(ofs);
    lane_hi   = (kind == KIND_BYTE4) && code[0];
    bit_sel   = code[3:0];
  end
endmodule

// File: rtl/ctxbank_ram.sv
module ctxbank_ram
  import ctxbank_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first synchronous RAM with per-lane write enables
  always_ff @(posedge clk) begin
    rdata_q <= mem[idx];
    for (int l = 0; l < LANES; l++) begin
      if (we && be[l]) mem[idx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/ctxbank_unit.sv
module ctxbank_unit
  import ctxbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_load,
  input  logic [ADDR_W-1:0] cp_load_val,
  input  logic              cp_swap,
  input  logic [ADDR_W-1:0] cp_swap_val,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_kind,
  input  logic [7:0]        acc_code,
  input  logic [15:0]       acc_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] cp_value,
  output logic [ADDR_W-1:0] swap_old,
  output logic              swap_done
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic rst_s;
  ctxbank_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s));

  logic [ADDR_W-1:0] cp_q;
  ctxbank_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_s),
    .load_en(cp_load), .load_val(cp_load_val),
    .swap_en(cp_swap), .swap_val(cp_swap_val),
    .cp_q(cp_q), .old_q(swap_old), .done_q(swap_done)
  );

  acc_kind_e         kind;
  logic [ADDR_W-1:0] byte_addr;
  logic              lane_hi;
  logic [3:0]        bit_sel;
  assign kind = acc_kind_e'(acc_kind);

  ctxbank_addr #(.ADDR_W(ADDR_W)) u_addr (
    .cp(cp_q), .kind(kind), .code(acc_code),
    .byte_addr(byte_addr), .lane_hi(lane_hi), .bit_sel(bit_sel)
  );

  // pipeline state
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] wb_idx_q;
  logic [3:0]       wb_bit_q;
  logic             wb_val_q, wb_en;
  logic             rd_pend_q, rd_pend_d, rd_en;
  acc_kind_e        rd_kind_q;
  logic [3:0]       rd_sel_q;

  logic              issue, is_bit, is_byte;
  logic [IDX_W-1:0]  ram_idx;
  logic              ram_we;
  logic [LANES-1:0]  ram_be;
  logic [DATA_W-1:0] ram_wdata, ram_q, patched;

  always_comb begin
    issue     = acc_valid && !busy_q;
    is_bit    = (kind == KIND_BIT8);
    is_byte   = (kind == KIND_BYTE4);
    busy_d    = issue && acc_write && is_bit;
    wb_en     = busy_d;
    rd_pend_d = issue && !acc_write;
    rd_en     = rd_pend_d;

    patched = ram_q;
    patched[wb_bit_q] = wb_val_q;

    if (busy_q) begin
      ram_idx   = wb_idx_q;
      ram_we    = 1'b1;
      ram_be    = '1;
      ram_wdata = patched;
    end else begin
      ram_idx   = byte_addr[ADDR_W-1:1];
      ram_we    = issue && acc_write && !is_bit;
      ram_be    = is_byte ? (lane_hi ? 2'b10 : 2'b01) : 2'b11;
      ram_wdata = is_byte ? {2{acc_wdata[7:0]}} : acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      wb_idx_q  <= '0;
      wb_bit_q  <= '0;
      wb_val_q  <= 1'b0;
      rd_kind_q <= KIND_WORD4;
      rd_sel_q  <= '0;
    end else begin
      busy_q    <= busy_d;
      rd_pend_q <= rd_pend_d;
      if (wb_en) begin
        wb_idx_q <= byte_addr[ADDR_W-1:1];
        wb_bit_q <= bit_sel;
        wb_val_q <= acc_wdata[0];
      end
      if (rd_en) begin
        rd_kind_q <= kind;
        rd_sel_q  <= is_byte ? {3'b000, lane_hi} : bit_sel;
      end
    end
  end

  ctxbank_ram #(.IDX_W(IDX_W)) u_ram (
    .clk(clk), .idx(ram_idx), .we(ram_we), .be(ram_be),
    .wdata(ram_wdata), .rdata_q(ram_q)
  );

  always_comb begin
    unique case (rd_kind_q)
      KIND_BYTE4: rd_data = {8'h00, rd_sel_q[0] ? ram_q[15:8] : ram_q[7:0]};
      KIND_BIT8:  rd_data = {15'b0, ram_q[rd_sel_q]};
      default:    rd_data = ram_q;
    endcase
  end

  assign busy     = busy_q;
  assign rd_valid = rd_pend_q;
  assign cp_value = cp_q;

  logic [IDX_W-1:0] rel_idx;
  assign rel_idx = ram_idx - cp_q[ADDR_W-1:1];

  assert_no_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |-> !acc_valid);

  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |=> !busy_q);

  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |-> $past(acc_valid && acc_write && acc_kind == 2'b10));

  assert_rd_cause_R10: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> $past(acc_valid && !acc_write));

  assert_rd_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !(rd_valid && busy));

  assert_byte_low_half_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (ram_we && ram_be != 2'b11) |-> (rel_idx < IDX_W'(8)));

  assert_addr_even_R7: assert property (@(posedge clk) disable iff (!rst_s)
    acc_valid |-> !byte_addr[0]);
endmodule

// File: tb/ctxbank_unit_bench.sv
`timescale 1ns/1ps
module ctxbank_unit_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          cp_load, cp_swap, acc_valid, acc_write;
  logic [AW-1:0] cp_load_val, cp_swap_val;
  logic [1:0]    acc_kind;
  logic [7:0]    acc_code;
  logic [15:0]   acc_wdata;
  logic          busy, rd_valid, swap_done;
  logic [15:0]   rd_data;
  logic [AW-1:0] cp_value, swap_old;

  ctxbank_unit #(.ADDR_W(AW)) u_ctxbank_unit (
    .clk(clk), .rst_n(rst_n),
    .cp_load(cp_load), .cp_load_val(cp_load_val),
    .cp_swap(cp_swap), .cp_swap_val(cp_swap_val),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_kind(acc_kind),
    .acc_code(acc_code), .acc_wdata(acc_wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .cp_value(cp_value), .swap_old(swap_old), .swap_done(swap_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 0;
  string cur_tag = "R2";

  // behavioural reference model
  logic [7:0]    mm [256];
  logic [AW-1:0] mcp, e_so;
  logic          e_rv, e_busy, e_sd;
  logic [15:0]   e_rd;
  string         e_tag = "R2";

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mcp = '0; e_so = '0; e_rv = 0; e_busy = 0; e_sd = 0; e_rd = '0;
    end else begin
      int rn, a;
      logic [15:0] w;
      e_rv = 0; e_busy = 0;
      e_sd = cp_swap;
      if (cp_swap) e_so = mcp;
      if (acc_valid) begin
        case (acc_kind)
          2'b00: rn = int'(acc_code[3:0]);
          2'b01: rn = int'(acc_code[3:1]);
          2'b10: rn = int'(acc_code[7:4]);
          default: rn = int'(acc_code[1:0]);
        endcase
        a = (int'(mcp) + 2 * rn) % 256;
        w = {mm[a + 1], mm[a]};
        e_tag = cur_tag;
        if (!acc_write) begin
          e_rv = 1;
          case (acc_kind)
            2'b01: e_rd = {8'h00, acc_code[0] ? w[15:8] : w[7:0]};
            2'b10: e_rd = {15'b0, w[acc_code[3:0]]};
            default: e_rd = w;
          endcase
        end else begin
          case (acc_kind)
            2'b01: if (acc_code[0]) mm[a + 1] = acc_wdata[7:0]; else mm[a] = acc_wdata[7:0];
            2'b10: begin
              w[acc_code[3:0]] = acc_wdata[0];
              mm[a] = w[7:0]; mm[a + 1] = w[15:8];
              e_busy = 1;
            end
            default: begin mm[a] = acc_wdata[7:0]; mm[a + 1] = acc_wdata[15:8]; end
          endcase
        end
      end
      if (cp_swap)      mcp = cp_swap_val & 8'hFE;
      else if (cp_load) mcp = cp_load_val & 8'hFE;
    end
  end

  // comparison every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      check("R10", rd_valid, e_rv);
      if (e_rv) check(e_tag, rd_data, e_rd);
      check("R6", busy, e_busy);
      check("R7", cp_value, mcp);
      check("R8", swap_done, e_sd);
      if (e_sd) check("R8", swap_old, e_so);
    end
  end

  task automatic cyc(bit v, bit wr, logic [1:0] k, logic [7:0] c, logic [15:0] d,
                     bit ld = 0, logic [7:0] lv = 0, bit sw = 0, logic [7:0] sv = 0,
                     string tag = "R2");
    @(posedge clk); #1;
    acc_valid = v; acc_write = wr; acc_kind = k; acc_code = c; acc_wdata = d;
    cp_load = ld; cp_load_val = lv; cp_swap = sw; cp_swap_val = sv;
    cur_tag = tag;
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'b00, 8'h00, 16'h0000);
  endtask

  task automatic load_cp(logic [7:0] v, string tag = "R7");
    cyc(0, 0, 2'b00, 8'h00, 16'h0, 1, v, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10: watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_kind = 0; acc_code = 0; acc_wdata = 0;
    cp_load = 0; cp_load_val = 0; cp_swap = 0; cp_swap_val = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cp_value, 0);
    check("R1", rd_valid, 0);
    check("R1", busy, 0);
    check("R1", swap_done, 0);
    chk_on = 1;

    // fill the whole RAM through the word view
    for (int b = 0; b < 8; b++) begin
      load_cp(8'(b * 32));
      for (int r = 0; r < 16; r++) cyc(1, 1, 2'b00, 8'(r), 16'(b * 4096 + r * 257 + 3));
    end

    // R2: bank at 0x40, distinct words, read back
    load_cp(8'h40);
    for (int r = 0; r < 16; r++) cyc(1, 1, 2'b00, 8'(r), 16'hC000 + 16'(r * 17), .tag("R2"));
    for (int r = 0; r < 16; r++) cyc(1, 0, 2'b00, 8'(r), 0, .tag("R2"));

    // R3: byte lanes overlay low words
    cyc(1, 1, 2'b01, 8'd2, 16'hFFA5, .tag("R3"));
    cyc(1, 1, 2'b01, 8'd7, 16'h003C, .tag("R3"));
    cyc(1, 0, 2'b00, 8'd1, 0, .tag("R3"));
    cyc(1, 0, 2'b00, 8'd3, 0, .tag("R3"));
    for (int b = 0; b < 16; b++) cyc(1, 0, 2'b01, 8'(b), 0, .tag("R3"));

    // R4: short codes ignore upper bits
    cyc(1, 0, 2'b11, 8'hFE, 0, .tag("R4"));
    cyc(1, 1, 2'b11, 8'hA9, 16'h1234, .tag("R4"));
    cyc(1, 0, 2'b00, 8'd1, 0, .tag("R4"));
    cyc(1, 0, 2'b11, 8'h03, 0, .tag("R4"));

    // R5 bit reads, R6 bit set/clear with write-back
    for (int i = 0; i < 16; i++) cyc(1, 0, 2'b10, {4'd5, 4'(i)}, 0, .tag("R5"));
    cyc(1, 1, 2'b10, 8'hC3, 16'h0001, .tag("R6")); idle();
    cyc(1, 1, 2'b10, 8'hCF, 16'h0000, .tag("R6")); idle();
    cyc(1, 1, 2'b10, 8'h0F, 16'hFFFE, .tag("R6")); idle();
    cyc(1, 0, 2'b00, 8'd12, 0, .tag("R6"));
    cyc(1, 0, 2'b00, 8'd0, 0, .tag("R6"));

    // R7: odd pointer aligned; access after and with load
    load_cp(8'h81);
    cyc(1, 0, 2'b00, 8'd0, 0, .tag("R7"));
    cyc(1, 1, 2'b00, 8'd4, 16'hBEEF, 1, 8'h40, .tag("R7"));
    cyc(1, 0, 2'b00, 8'd4, 0, .tag("R7"));

    // R8 swaps, R11 bank independence
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 8'hA0, "R8");
    for (int r = 0; r < 16; r++) cyc(1, 1, 2'b00, 8'(r), 16'h5A00 + 16'(r), .tag("R11"));
    cyc(0, 0, 2'b00, 0, 0, 1, 8'h20, 1, 8'h41, "R8");
    for (int r = 0; r < 16; r++) cyc(1, 0, 2'b00, 8'(r), 0, .tag("R11"));
    cyc(1, 0, 2'b00, 8'd9, 0, 0, 0, 1, 8'hA0, "R11");
    cyc(1, 0, 2'b00, 8'd9, 0, .tag("R11"));

    // R9: wrap past the top of the RAM
    load_cp(8'hF0);
    cyc(1, 1, 2'b00, 8'd15, 16'h7E57, .tag("R9"));
    cyc(1, 1, 2'b01, 8'd15, 16'h0099, .tag("R9"));
    load_cp(8'h00);
    cyc(1, 0, 2'b00, 8'd7, 0, .tag("R9"));

    // R10: back-to-back reads then a write
    cyc(1, 0, 2'b00, 8'd1, 0, .tag("R10"));
    cyc(1, 0, 2'b01, 8'd3, 0, .tag("R10"));
    cyc(1, 1, 2'b00, 8'd2, 16'h0F0F, .tag("R10"));
    idle(2);

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [1:0] k;
      bit wr;
      k  = 2'($urandom);
      wr = 1'($urandom);
      cyc(($urandom % 4) != 0, wr, k, 8'($urandom), 16'($urandom),
          ($urandom % 12) == 0, 8'($urandom), ($urandom % 16) == 0, 8'($urandom), "R2");
      if (acc_valid && wr && k == 2'b10) idle();
    end
    idle(3);
    finish_run();
  end
endmodule